// File: doc/BRIEF.md
# Three-Stage Averaging Decimator with Delay-Corrected Timestamps

This block takes signed 16-bit converter samples, each tagged with a 32-bit count of input sample ticks. It runs them through three decimating averagers connected in series. The first averager always reduces the rate by ten. The second takes the first one's output and the third takes the second one's output, and each of these two reduces the rate by a factor chosen from 2, 4, 5, 8 or 10. Every stage has its own output port, so three sample rates come out at once. For example, a 2000 samples/s input with factors 4 and 5 gives 200, 50 and 10 samples/s together.

Each stage adds up one window of N inputs and emits the floor of their mean. The mean is saturated to the signed 16-bit range. Division by 2, 4 or 8 is an arithmetic shift, and division by 5 or 10 is a fixed multiply-and-shift. Each output carries a timestamp that places the sample at the centre of its window in input ticks. This removes the delay that the averaging adds. A host writes one byte at a time to set the factors of stages two and three while data is running. An illegal code is rejected and reported.

Top module: `decim_chain`

## Requirements
- R1: Stage one emits, on `o1_*`, one sample for every 10 accepted inputs (`smp_valid` high). Its value is floor(sum/10) of those 10 inputs.
- R2: Stage two averages consecutive stage-one outputs and stage three averages consecutive stage-two outputs, each over its own programmed factor N. Each emits floor(sum/N). All three output ports run concurrently.
- R3: A host write (`cfg_we` high for one cycle) with `cfg_sel`=0 sets the stage-two factor and with `cfg_sel`=1 sets the stage-three factor. The byte `cfg_byte` is the factor value itself. Only 2, 4, 5, 8 and 10 are legal. After reset the factors are 4 (stage two) and 5 (stage three).
- R4: For a write with an illegal byte, `cfg_bad` is high in the cycle after the write and low in the cycle after that. Both factors stay unchanged, and windows already in progress continue undisturbed.
- R5: A legal write discards the partly filled window of the addressed stage and of every later stage. Their next windows start with the next sample they receive.
- R6: Each output valid is high for exactly one cycle per sample. It rises on the clock edge that registers the input completing the window.
- R7: An output timestamp is the timestamp of the first sample of its window plus floor((N−1)·P/2). P is the stage's input spacing in input ticks: 1 for stage one, 10 for stage two, and 10 times the stage-two factor for stage three. The result wraps modulo 2^32.
- R8: During and right after reset, all output valids and `cfg_bad` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Input sample strobe |
| smp_data | input | 16 | Signed input sample |
| smp_tick | input | 32 | Input sample tick count |
| cfg_we | input | 1 | Host write strobe |
| cfg_sel | input | 1 | 0 selects stage two, 1 selects stage three |
| cfg_byte | input | 8 | Factor value written |
| cfg_bad | output | 1 | One-cycle pulse on an illegal factor write |
| o1_valid | output | 1 | Stage-one output strobe |
| o1_data | output | 16 | Stage-one averaged sample |
| o1_tick | output | 32 | Stage-one corrected timestamp |
| o2_valid | output | 1 | Stage-two output strobe |
| o2_data | output | 16 | Stage-two averaged sample |
| o2_tick | output | 32 | Stage-two corrected timestamp |
| o3_valid | output | 1 | Stage-three output strobe |
| o3_data | output | 16 | Stage-three averaged sample |
| o3_tick | output | 32 | Stage-three corrected timestamp |

## Verification
The hardest state to reach is a reconfiguration that lands while stages two and three both hold partly filled windows. Stage three fills only once every 10·N2·N3 inputs. Each configuration phase therefore sends three full stage-three windows plus a few extra samples, and then writes the new factors, so every flush discards real partial sums. Illegal codes are also written in the middle of a window, and the next outputs must still match a model whose windows were never cleared. Sample patterns of small values near zero and minus one test the floor rounding of negative sums. Patterns at the extremes test the widest accumulator values.

// File: rtl/decim_pkg.sv
package decim_pkg;
   localparam int FACW = 4;          // width of a factor code inside the chain
   localparam int FIRST_FACTOR = 10; // stage one rate reduction

   function automatic logic legal_code(input logic [7:0] c);
      return (c == 8'd2) || (c == 8'd4) || (c == 8'd5) || (c == 8'd8) || (c == 8'd10);
   endfunction
endpackage

// File: rtl/decim_div.sv
module decim_div #(
   parameter int ACCW = 20
) (
   input  logic signed [ACCW-1:0]           sum,
   input  logic [decim_pkg::FACW-1:0]       fac,
   output logic signed [ACCW-1:0]           quo
);
   localparam int    K  = ACCW + 2;
   localparam int    PW = ACCW + 1 + K;
   localparam longint M = ((64'sd1 <<< K) + 64'sd4) / 64'sd5;

   if (ACCW > 40) begin : g_bad_width
      $error("decim_div: ACCW too large for the reciprocal constant");
   end

   logic                   neg;
   logic [ACCW:0]          mag;
   logic [PW-1:0]          prod;
   logic [ACCW:0]          q5;
   logic signed [ACCW+1:0] d5;

   always_comb begin
      neg  = sum[ACCW-1];
      // floor for negatives: -floor((-x + 4) / 5)
      mag  = neg ? ((~{sum[ACCW-1], sum}) + (ACCW+1)'(5)) : {1'b0, sum};
      prod = PW'(mag) * PW'(M);
      q5   = (ACCW+1)'(prod >> K);
      d5   = neg ? -$signed({1'b0, q5}) : $signed({1'b0, q5});
      case (fac)
         4'd2:    quo = sum >>> 1;
         4'd4:    quo = sum >>> 2;
         4'd8:    quo = sum >>> 3;
         4'd5:    quo = ACCW'(d5);
         default: quo = ACCW'(d5 >>> 1);
      endcase
   end
endmodule

// File: rtl/decim_cfg.sv
module decim_cfg #(
   parameter int DEF2 = 4,
   parameter int DEF3 = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic                         sel,
   input  logic [7:0]                   wbyte,
   output logic [decim_pkg::FACW-1:0]   fac2,
   output logic [decim_pkg::FACW-1:0]   fac3,
   output logic                         flush2,
   output logic                         flush3,
   output logic                         bad
);
   import decim_pkg::*;

   if (!legal_code(8'(DEF2)) || !legal_code(8'(DEF3))) begin : g_bad_default
      $error("decim_cfg: default factor outside the legal set");
   end

   logic ok;
   assign ok     = legal_code(wbyte);
   assign flush2 = we && ok && !sel;
   assign flush3 = we && ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fac2 <= FACW'(DEF2);
         fac3 <= FACW'(DEF3);
         bad  <= 1'b0;
      end else begin
         bad <= we && !ok;
         if (we && ok && !sel) fac2 <= FACW'(wbyte);
         if (we && ok &&  sel) fac3 <= FACW'(wbyte);
      end
   end

   // R4
   bad_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !ok) |=> ($stable(fac2) && $stable(fac3)));
   // R3
   legal_fac_chk: assert property (@(posedge clk) disable iff (!rst_n)
      legal_code(8'(fac2)) && legal_code(8'(fac3)));
endmodule

// File: rtl/decim_stage.sv
module decim_stage #(
   parameter int DW      = 16,
   parameter int TSW     = 32,
   parameter int ACCW    = DW + 4,
   parameter int FIXED_N = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic [decim_pkg::FACW-1:0]   factor,
   input  logic [TSW-1:0]               period,
   input  logic                         in_v,
   input  logic signed [DW-1:0]         in_d,
   input  logic [TSW-1:0]               in_ts,
   output logic                         out_v,
   output logic signed [DW-1:0]         out_d,
   output logic [TSW-1:0]               out_ts
);
   import decim_pkg::*;

   localparam logic signed [ACCW-1:0] SMAX = ACCW'((64'sd1 <<< (DW-1)) - 1);
   localparam logic signed [ACCW-1:0] SMIN = -ACCW'(64'sd1 <<< (DW-1));

   if (ACCW < DW + 4) begin : g_bad_acc
      $error("decim_stage: accumulator narrower than DW + log2(10)");
   end

   logic [FACW-1:0] n;
   if (FIXED_N != 0) begin : g_fixed
      if (!legal_code(8'(FIXED_N))) begin : g_bad_fixed
         $error("decim_stage: fixed factor outside the legal set");
      end
      assign n = FACW'(FIXED_N);
   end else begin : g_prog
      assign n = factor;
   end

   logic signed [ACCW-1:0] acc, in_ext, sum, quo;
   logic [FACW-1:0]        cnt;
   logic [TSW-1:0]         first_ts, offset;
   logic                   last;

   assign in_ext = {{(ACCW-DW){in_d[DW-1]}}, in_d};
   assign sum    = acc + in_ext;
   assign last   = in_v && (cnt == n - FACW'(1));
   assign offset = ((TSW'(n) - TSW'(1)) * period) >> 1;

   decim_div #(.ACCW(ACCW)) u_div (.sum(sum), .fac(n), .quo(quo));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc      <= '0;
         cnt      <= '0;
         first_ts <= '0;
         out_v    <= 1'b0;
         out_d    <= '0;
         out_ts   <= '0;
      end else begin
         out_v <= 1'b0;
         if (flush) begin
            acc      <= in_v ? in_ext : '0;
            cnt      <= in_v ? FACW'(1) : '0;
            first_ts <= in_ts;
         end else if (last) begin
            out_v  <= 1'b1;
            out_d  <= (quo > SMAX) ? DW'(SMAX) : (quo < SMIN) ? DW'(SMIN) : DW'(quo);
            out_ts <= first_ts + offset;
            acc    <= '0;
            cnt    <= '0;
         end else if (in_v) begin
            acc <= sum;
            cnt <= cnt + FACW'(1);
            if (cnt == '0) first_ts <= in_ts;
         end
      end
   end

   // R6
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_v |=> !out_v);
   // R6
   out_follows_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_v |-> $past(in_v));
   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < n);
endmodule

// File: rtl/decim_chain.sv
module decim_chain #(
   parameter int DW   = 16,
   parameter int TSW  = 32,
   parameter int DEF2 = 4,
   parameter int DEF3 = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_valid,
   input  logic signed [DW-1:0] smp_data,
   input  logic [TSW-1:0]       smp_tick,
   input  logic                 cfg_we,
   input  logic                 cfg_sel,
   input  logic [7:0]           cfg_byte,
   output logic                 cfg_bad,
   output logic                 o1_valid,
   output logic signed [DW-1:0] o1_data,
   output logic [TSW-1:0]       o1_tick,
   output logic                 o2_valid,
   output logic signed [DW-1:0] o2_data,
   output logic [TSW-1:0]       o2_tick,
   output logic                 o3_valid,
   output logic signed [DW-1:0] o3_data,
   output logic [TSW-1:0]       o3_tick
);
   import decim_pkg::*;

   localparam int ACCW = DW + 4;

   logic [FACW-1:0] fac2, fac3;
   logic            fl2, fl3;
   logic [TSW-1:0]  per3;

   assign per3 = TSW'(FIRST_FACTOR) * TSW'(fac2);

   decim_cfg #(.DEF2(DEF2), .DEF3(DEF3)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wbyte(cfg_byte),
      .fac2(fac2), .fac3(fac3), .flush2(fl2), .flush3(fl3), .bad(cfg_bad));

   decim_stage #(.DW(DW), .TSW(TSW), .ACCW(ACCW), .FIXED_N(FIRST_FACTOR)) u_s1 (
      .clk(clk), .rst_n(rst_n), .flush(1'b0), .factor(FACW'(FIRST_FACTOR)),
      .period(TSW'(1)), .in_v(smp_valid), .in_d(smp_data), .in_ts(smp_tick),
      .out_v(o1_valid), .out_d(o1_data), .out_ts(o1_tick));

   decim_stage #(.DW(DW), .TSW(TSW), .ACCW(ACCW), .FIXED_N(0)) u_s2 (
      .clk(clk), .rst_n(rst_n), .flush(fl2), .factor(fac2),
      .period(TSW'(FIRST_FACTOR)), .in_v(o1_valid), .in_d(o1_data), .in_ts(o1_tick),
      .out_v(o2_valid), .out_d(o2_data), .out_ts(o2_tick));

   decim_stage #(.DW(DW), .TSW(TSW), .ACCW(ACCW), .FIXED_N(0)) u_s3 (
      .clk(clk), .rst_n(rst_n), .flush(fl3), .factor(fac3),
      .period(per3), .in_v(o2_valid), .in_d(o2_data), .in_ts(o2_tick),
      .out_v(o3_valid), .out_d(o3_data), .out_ts(o3_tick));

   // R2
   chain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o3_valid |-> $past(o2_valid));
   // R8
   quiet_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!o1_valid && !o2_valid && !o3_valid && !cfg_bad));
endmodule

// File: tb/sim_decim_chain.sv
module sim_decim_chain;
   localparam time TCLK = 10ns;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_valid = 1'b0;
   logic signed [15:0] smp_data = '0;
   logic [31:0]        smp_tick = '0;
   logic               cfg_we = 1'b0;
   logic               cfg_sel = 1'b0;
   logic [7:0]         cfg_byte = '0;
   logic               cfg_bad;
   logic               o1_valid, o2_valid, o3_valid;
   logic signed [15:0] o1_data, o2_data, o3_data;
   logic [31:0]        o1_tick, o2_tick, o3_tick;

   always #(TCLK/2) clk = ~clk;

   decim_chain u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .smp_tick(smp_tick), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_byte(cfg_byte),
      .cfg_bad(cfg_bad), .o1_valid(o1_valid), .o1_data(o1_data), .o1_tick(o1_tick),
      .o2_valid(o2_valid), .o2_data(o2_data), .o2_tick(o2_tick),
      .o3_valid(o3_valid), .o3_data(o3_data), .o3_tick(o3_tick));

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   bit run_mon = 1'b0;

   // bench model
   int     macc[3];
   int     mcnt[3];
   longint mfirst[3];
   int     mfac[3];
   int     eq_d0[$], eq_d1[$], eq_d2[$];
   longint eq_t0[$], eq_t1[$], eq_t2[$];
   int     seen[3];
   longint tick = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int floor_div(input int a, input int b);
      int q;
      q = a / b;
      if ((a % b) != 0 && a < 0) q = q - 1;
      return q;
   endfunction

   task automatic model_in(input int s, input int d, input longint ts);
      int avg;
      longint per, ots;
      if (mcnt[s] == 0) mfirst[s] = ts;
      macc[s] += d;
      mcnt[s]++;
      if (mcnt[s] == mfac[s]) begin
         avg = floor_div(macc[s], mfac[s]);
         per = (s == 0) ? 1 : (s == 1) ? 10 : 10 * mfac[1];
         ots = (mfirst[s] + ((mfac[s] - 1) * per) / 2) & 64'hFFFF_FFFF;
         case (s)
            0: begin eq_d0.push_back(avg); eq_t0.push_back(ots); end
            1: begin eq_d1.push_back(avg); eq_t1.push_back(ots); end
            default: begin eq_d2.push_back(avg); eq_t2.push_back(ots); end
         endcase
         macc[s] = 0;
         mcnt[s] = 0;
         if (s < 2) model_in(s + 1, avg, ots);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // output monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (run_mon) begin
         if (o1_valid) begin
            seen[0]++;
            if (eq_d0.size() == 0) check(1'b0, "R1 unexpected o1", 1, 0);
            else begin
               int ed; longint et;
               ed = eq_d0.pop_front(); et = eq_t0.pop_front();
               check(int'(o1_data) == ed, "R1 o1_data", int'(o1_data), ed);
               check(longint'(o1_tick) == et, "R7 o1_tick", longint'(o1_tick), et);
            end
         end
         if (o2_valid) begin
            seen[1]++;
            if (eq_d1.size() == 0) check(1'b0, "R5 unexpected o2", 1, 0);
            else begin
               int ed; longint et;
               ed = eq_d1.pop_front(); et = eq_t1.pop_front();
               check(int'(o2_data) == ed, "R2 o2_data", int'(o2_data), ed);
               check(longint'(o2_tick) == et, "R7 o2_tick", longint'(o2_tick), et);
            end
         end
         if (o3_valid) begin
            seen[2]++;
            if (eq_d2.size() == 0) check(1'b0, "R5 unexpected o3", 1, 0);
            else begin
               int ed; longint et;
               ed = eq_d2.pop_front(); et = eq_t2.pop_front();
               check(int'(o3_data) == ed, "R2 o3_data", int'(o3_data), ed);
               check(longint'(o3_tick) == et, "R7 o3_tick", longint'(o3_tick), et);
            end
         end
      end
   end

   task automatic send(input int d, input bit gap);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = 16'(d);
      smp_tick  = 32'(tick);
      model_in(0, d, tick);
      tick++;
      if (gap) begin
         @(negedge clk);
         smp_valid = 1'b0;
      end
   endtask

   function automatic int pick(input int mode);
      int r;
      case (mode)
         0: r = int'($signed(16'($urandom)));
         1: r = int'($urandom % 6) - 3;
         default: r = ($urandom % 2) ? 32767 : -32768;
      endcase
      return r;
   endfunction

   task automatic burst(input int count, input int mode);
      for (int i = 0; i < count; i++) send(pick(mode), ($urandom % 4) == 0);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic host_write(input bit sel, input int val, input bit expect_bad);
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (4) @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_byte = 8'(val);
      if (!expect_bad) begin
         if (!sel) begin
            mfac[1] = val;
            macc[1] = 0; mcnt[1] = 0;
         end else mfac[2] = val;
         macc[2] = 0; mcnt[2] = 0;
      end
      @(negedge clk);
      cfg_we = 1'b0;
      check(cfg_bad == expect_bad, expect_bad ? "R4 bad pulse" : "R3 no bad on legal",
            longint'(cfg_bad), longint'(expect_bad));
      @(negedge clk);
      check(cfg_bad == 1'b0, "R4 bad one cycle", longint'(cfg_bad), 0);
   endtask

   initial begin
      int f2s[6] = '{2, 10, 8, 5, 2, 4};
      int f3s[6] = '{2, 10, 5, 8, 10, 4};
      int seed = 32'h5EED;
      void'($urandom(seed));
      mfac[0] = 10; mfac[1] = 4; mfac[2] = 5;
      for (int s = 0; s < 3; s++) begin macc[s] = 0; mcnt[s] = 0; mfirst[s] = 0; seen[s] = 0; end

      repeat (3) @(negedge clk);
      // R8 reset state
      check(!o1_valid && !o2_valid && !o3_valid, "R8 valids in reset", 
            longint'({o1_valid, o2_valid, o3_valid}), 0);
      check(cfg_bad == 1'b0, "R8 cfg_bad in reset", longint'(cfg_bad), 0);
      @(negedge clk);
      rst_n = 1'b1;
      run_mon = 1'b1;
      @(negedge clk);
      check(!o1_valid && !o2_valid && !o3_valid, "R8 valids after reset",
            longint'({o1_valid, o2_valid, o3_valid}), 0);

      // R3 default factors 4 and 5, R1/R2 random and extreme data
      burst(600, 0);
      burst(400, 2);
      burst(207, 1);

      // R5 reconfigure mid-window across the legal set
      for (int k = 0; k < 6; k++) begin
         host_write(1'b0, f2s[k], 1'b0);
         host_write(1'b1, f3s[k], 1'b0);
         burst(10 * f2s[k] * f3s[k] * 3 + 13, k % 3);
      end

      // R4 illegal codes mid-window: nothing changes
      host_write(1'b0, 3, 1'b1);
      host_write(1'b1, 0, 1'b1);
      host_write(1'b0, 255, 1'b1);
      host_write(1'b1, 9, 1'b1);
      burst(10 * 4 * 4 * 2, 1);

      repeat (8) @(negedge clk);
      check(eq_d0.size() == 0, "R1 pending o1", eq_d0.size(), 0);
      check(eq_d1.size() == 0, "R2 pending o2", eq_d1.size(), 0);
      check(eq_d2.size() == 0, "R2 pending o3", eq_d2.size(), 0);
      check(seen[2] > 10, "R2 o3 produced", seen[2], 11);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end
endmodule